// File: doc/BRIEF.md
# CAN Transmit Queue Sequencer

This block sits between a host and a CAN bit engine. The host loads outgoing messages into a first-in first-out queue with a default depth of eight. Each message carries a standard or extended identifier, a length code, up to eight data bytes and a host tag. The sequencer moves messages one at a time from the head of the queue into a single holding buffer. It presents that buffer to the bit engine through a request line, and the engine answers with one-cycle pulses for success, lost arbitration or bus error.

The queue drains in two ways. While either enable input is high, messages flow through continuously. While both are low, a single-shot request releases exactly one message. A failed message is kept and retried. In one-shot mode it is dropped instead, and the next message is taken. An abort command empties the holding buffer and leaves the queue as it is. A bus error raises a sticky flag, and that flag can drive an interrupt.

Top module: `can_txq_seq`

## Requirements
- R1: The queue holds up to DEPTH (default 8) messages. A load while the queue holds DEPTH messages is dropped. `q_full` is 1 exactly when the queue holds DEPTH messages.
- R2: A `q_clear` pulse empties the queue, so `q_count` reads 0 on the next cycle. A load presented in the same cycle is dropped.
- R3: With IDE=1 the 29-bit identifier is presented unchanged on `eng_id`. With IDE=0 only bits 10:0 are presented, and bits 28:11 read 0.
- R4: A length code above 8 is presented as 8. Data byte k occupies bits 8k+7:8k, with byte 0 sent first. Every byte k at or above the effective length reads 0 on `eng_data`.
- R5: The host tag of a message is presented unchanged on `eng_tag` while that message is held.
- R6: While `en_pin` OR `en_bit` is 1, queued messages enter the holding buffer in load order. The next message enters one cycle after the buffer empties. `eng_req` is 1 while the buffer holds a message.
- R7: While both enables are 0, a `single_req` pulse sets `single_pend`. The next move into the holding buffer clears it, so exactly one message is sent.
- R8: Dropping both enables while a message is held keeps `eng_req` high until that message ends. No further queued message is then started.
- R9: With `oneshot` = 0, a lost-arbitration or bus-error pulse keeps the message held. `eng_req` stays 1 and the message contents do not change.
- R10: With `oneshot` = 1, a lost-arbitration or bus-error pulse discards the held message. The next queued message is loaded one cycle later if an enable is active.
- R11: A bus-error pulse while a message is held sets `bus_err`, which stays set until an `err_clr` pulse (a new error wins over the clear). `irq` equals `bus_err` AND `err_ie`.
- R12: An `abort_cmd` pulse empties the holding buffer on the next cycle and leaves the queue contents and count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Load command strobe |
| ld_ide | input | 1 | 1 = extended identifier |
| ld_id | input | 29 | Identifier |
| ld_dlc | input | 4 | Data length code |
| ld_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| ld_tag | input | 8 | Host message tag |
| q_clear | input | 1 | Empty the queue |
| abort_cmd | input | 1 | Cancel the held message |
| en_pin | input | 1 | Continuous transmit enable (pin) |
| en_bit | input | 1 | Continuous transmit enable (control bit) |
| single_req | input | 1 | Request a single-message send |
| oneshot | input | 1 | Discard failed messages instead of retrying |
| err_ie | input | 1 | Bus-error interrupt enable |
| err_clr | input | 1 | Write-one-to-clear for `bus_err` |
| eng_ok | input | 1 | Engine: transmission succeeded |
| eng_lost | input | 1 | Engine: arbitration lost |
| eng_err | input | 1 | Engine: bus error |
| eng_req | output | 1 | Holding buffer valid, request to send |
| eng_ide | output | 1 | Held message format |
| eng_id | output | 29 | Held identifier, formatted |
| eng_dlc | output | 4 | Effective length |
| eng_data | output | 64 | Data with unused bytes zeroed |
| eng_tag | output | 8 | Held message tag |
| single_pend | output | 1 | Single-message request pending |
| q_count | output | 4 | Messages in the queue |
| q_full | output | 1 | Queue full |
| bus_err | output | 1 | Sticky bus-error flag |
| irq | output | 1 | Interrupt |

## Verification
The checker watches several rules on every cycle: the queue never counts past its depth, and a clear always leaves it empty. An abort always empties the holding buffer. A failed message is retried with unchanged contents when one-shot mode is off and is dropped when it is on. With both enables low and no pending single-shot request, nothing new starts. The error flag stays set until it is cleared. Other behaviour only the bench scenarios can show: load order across a full queue, and the identifier and data formatting for each IDE and length case. They also show that a single-shot request sends exactly one message and that a paused queue keeps its remaining entries.

// File: rtl/cantx_pkg.sv
package cantx_pkg;
   localparam int ID_W      = 29;
   localparam int STD_ID_W  = 11;
   localparam int DLC_W     = 4;
   localparam int MAX_BYTES = 8;
   localparam int DATA_W    = MAX_BYTES * 8;
   localparam int TAG_W     = 8;

   typedef struct packed {
      logic              ide;
      logic [ID_W-1:0]   id;
      logic [DLC_W-1:0]  dlc;
      logic [DATA_W-1:0] data;
      logic [TAG_W-1:0]  tag;
   } txq_msg_t;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo
   import cantx_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       push,
   input  txq_msg_t                   push_msg,
   input  logic                       pop,
   output txq_msg_t                   head_msg,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       full,
   output logic                       empty
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH+1);
   localparam bit POW2  = (DEPTH == (1 << PTR_W));

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("txq_fifo: DEPTH must be at least 2");
      end
   endgenerate

   txq_msg_t          mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic              push_ok, pop_ok;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push & ~full & ~clr;
   assign pop_ok  = pop & ~empty & ~clr;

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_msg;
   end

   assign head_msg = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         if (push_ok && !pop_ok)      count <= count + 1'b1;
         else if (pop_ok && !push_ok) count <= count - 1'b1;
      end
   end
endmodule

// File: rtl/txq_hold.sv
module txq_hold
   import cantx_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     q_empty,
   input  txq_msg_t q_head,
   input  logic     q_clr,
   input  logic     tx_en,
   input  logic     single_set,
   input  logic     oneshot,
   input  logic     abort,
   input  logic     eng_ok,
   input  logic     eng_lost,
   input  logic     eng_err,
   input  logic     err_clr,
   output logic     pop,
   output logic     hold_v,
   output txq_msg_t hold_msg,
   output logic     single_pend,
   output logic     bus_err
);
   logic fetch, release_now, err_seen;

   assign fetch       = ~hold_v & ~q_empty & (tx_en | single_pend) & ~abort & ~q_clr;
   assign release_now = hold_v & (eng_ok | (oneshot & (eng_lost | eng_err)));
   assign err_seen    = hold_v & eng_err;
   assign pop         = fetch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v <= 1'b0;
      end else if (abort || release_now) begin
         hold_v <= 1'b0;
      end else if (fetch) begin
         hold_v <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hold_msg <= '0;
      else if (fetch) hold_msg <= q_head;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         single_pend <= 1'b0;
         bus_err     <= 1'b0;
      end else begin
         single_pend <= (single_pend & ~fetch) | single_set;
         bus_err     <= err_seen | (bus_err & ~err_clr);
      end
   end
endmodule

// File: rtl/txq_fmt.sv
module txq_fmt
   import cantx_pkg::*;
(
   input  txq_msg_t          msg,
   output logic [ID_W-1:0]   id,
   output logic [DLC_W-1:0]  dlc,
   output logic [DATA_W-1:0] data,
   output logic [TAG_W-1:0]  tag
);
   logic [DLC_W-1:0] eff_dlc;

   assign eff_dlc = (msg.dlc > DLC_W'(MAX_BYTES)) ? DLC_W'(MAX_BYTES) : msg.dlc;
   assign dlc     = eff_dlc;
   assign tag     = msg.tag;
   assign id      = msg.ide ? msg.id
                            : {{(ID_W-STD_ID_W){1'b0}}, msg.id[STD_ID_W-1:0]};

   generate
      for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
         assign data[8*b +: 8] = (eff_dlc > DLC_W'(b)) ? msg.data[8*b +: 8] : 8'h00;
      end
   endgenerate
endmodule

// File: rtl/can_txq_seq.sv
module can_txq_seq
   import cantx_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ld_valid,
   input  logic                       ld_ide,
   input  logic [28:0]                ld_id,
   input  logic [3:0]                 ld_dlc,
   input  logic [63:0]                ld_data,
   input  logic [7:0]                 ld_tag,
   input  logic                       q_clear,
   input  logic                       abort_cmd,
   input  logic                       en_pin,
   input  logic                       en_bit,
   input  logic                       single_req,
   input  logic                       oneshot,
   input  logic                       err_ie,
   input  logic                       err_clr,
   input  logic                       eng_ok,
   input  logic                       eng_lost,
   input  logic                       eng_err,
   output logic                       eng_req,
   output logic                       eng_ide,
   output logic [28:0]                eng_id,
   output logic [3:0]                 eng_dlc,
   output logic [63:0]                eng_data,
   output logic [7:0]                 eng_tag,
   output logic                       single_pend,
   output logic [$clog2(DEPTH+1)-1:0] q_count,
   output logic                       q_full,
   output logic                       bus_err
   ,output logic                      irq
);
   txq_msg_t ld_msg, head_msg, hold_msg;
   logic     q_empty, pop;

   assign ld_msg = '{ide: ld_ide, id: ld_id, dlc: ld_dlc, data: ld_data, tag: ld_tag};

   txq_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (q_clear),
      .push     (ld_valid),
      .push_msg (ld_msg),
      .pop      (pop),
      .head_msg (head_msg),
      .count    (q_count),
      .full     (q_full),
      .empty    (q_empty)
   );

   txq_hold u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .q_empty     (q_empty),
      .q_head      (head_msg),
      .q_clr       (q_clear),
      .tx_en       (en_pin | en_bit),
      .single_set  (single_req),
      .oneshot     (oneshot),
      .abort       (abort_cmd),
      .eng_ok      (eng_ok),
      .eng_lost    (eng_lost),
      .eng_err     (eng_err),
      .err_clr     (err_clr),
      .pop         (pop),
      .hold_v      (eng_req),
      .hold_msg    (hold_msg),
      .single_pend (single_pend),
      .bus_err     (bus_err)
   );

   txq_fmt u_fmt (
      .msg  (hold_msg),
      .id   (eng_id),
      .dlc  (eng_dlc),
      .data (eng_data),
      .tag  (eng_tag)
   );

   assign eng_ide = hold_msg.ide;
   assign irq     = bus_err & err_ie;
endmodule

// File: rtl/cantx_chk.sv
module cantx_chk #(
   parameter int DEPTH = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       q_clear,
   input logic                       abort_cmd,
   input logic                       en_pin,
   input logic                       en_bit,
   input logic                       oneshot,
   input logic                       err_clr,
   input logic                       eng_lost,
   input logic                       eng_err,
   input logic                       eng_req,
   input logic [28:0]                eng_id,
   input logic [3:0]                 eng_dlc,
   input logic [7:0]                 eng_tag,
   input logic                       single_pend,
   input logic [$clog2(DEPTH+1)-1:0] q_count,
   input logic                       q_full,
   input logic                       bus_err
);
   localparam int CNT_W = $clog2(DEPTH+1);

   always @(posedge clk) begin
      if (rst_n) begin
         assert_no_overflow_R1: assert (q_count <= CNT_W'(DEPTH));
         assert_full_flag_R1: assert (q_full == (q_count == CNT_W'(DEPTH)));
         assert_dlc_cap_R4: assert (eng_dlc <= 4'd8);
      end
   end

   assert_clear_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
      q_clear |=> (q_count == '0));

   assert_pause_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!eng_req && !(en_pin || en_bit) && !single_pend) |=> !eng_req);

   assert_retry_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && (eng_lost || eng_err) && !oneshot && !abort_cmd)
      |=> (eng_req && $stable(eng_tag) && $stable(eng_id)));

   assert_oneshot_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && (eng_lost || eng_err) && oneshot) |=> !eng_req);

   assert_err_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && eng_err) |=> bus_err);

   assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_err && !err_clr) |=> bus_err);

   assert_abort_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
      abort_cmd |=> !eng_req);
endmodule

bind can_txq_seq cantx_chk #(.DEPTH(DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .q_clear     (q_clear),
   .abort_cmd   (abort_cmd),
   .en_pin      (en_pin),
   .en_bit      (en_bit),
   .oneshot     (oneshot),
   .err_clr     (err_clr),
   .eng_lost    (eng_lost),
   .eng_err     (eng_err),
   .eng_req     (eng_req),
   .eng_id      (eng_id),
   .eng_dlc     (eng_dlc),
   .eng_tag     (eng_tag),
   .single_pend (single_pend),
   .q_count     (q_count),
   .q_full      (q_full),
   .bus_err     (bus_err)
);

// File: tb/sim_can_txq_seq.sv
`timescale 1ns/1ps
module sim_can_txq_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_valid = 0, ld_ide = 0;
   logic [28:0] ld_id = '0;
   logic [3:0]  ld_dlc = '0;
   logic [63:0] ld_data = '0;
   logic [7:0]  ld_tag = '0;
   logic        q_clear = 0, abort_cmd = 0, en_pin = 0, en_bit = 0, single_req = 0;
   logic        oneshot = 0, err_ie = 0, err_clr = 0, eng_ok = 0, eng_lost = 0, eng_err = 0;
   logic        eng_req, eng_ide, single_pend, q_full, bus_err, irq;
   logic [28:0] eng_id;
   logic [3:0]  eng_dlc, q_count;
   logic [63:0] eng_data;
   logic [7:0]  eng_tag;
   int          errors = 0, checks = 0;

   always #4 clk = ~clk;

   can_txq_seq u0 (.*);

   typedef struct packed {
      logic ide; logic [28:0] id; logic [3:0] dlc; logic [63:0] data; logic [7:0] tag;
      logic [28:0] eid; logic [3:0] edlc; logic [63:0] edata;
   } vec_t;

   localparam vec_t VEC [5] = '{
      '{1'b0, 29'h1ABCDEF5, 4'd3,  64'h8877665544332211, 8'h11, 29'h000006F5, 4'd3, 64'h0000000000332211},
      '{1'b1, 29'h1ABCDEF5, 4'd8,  64'hF0E1D2C3B4A59687, 8'hA5, 29'h1ABCDEF5, 4'd8, 64'hF0E1D2C3B4A59687},
      '{1'b1, 29'h00000123, 4'd15, 64'h0123456789ABCDEF, 8'h3C, 29'h00000123, 4'd8, 64'h0123456789ABCDEF},
      '{1'b0, 29'h000007FF, 4'd0,  64'hFFFFFFFFFFFFFFFF, 8'h00, 29'h000007FF, 4'd0, 64'h0000000000000000},
      '{1'b1, 29'h1FFFFFFF, 4'd9,  64'hDEADBEEFCAFEF00D, 8'hFF, 29'h1FFFFFFF, 4'd8, 64'hDEADBEEFCAFEF00D}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load(input logic ide, input logic [28:0] id, input logic [3:0] dlc,
                       input logic [63:0] data, input logic [7:0] tag);
      ld_valid = 1; ld_ide = ide; ld_id = id; ld_dlc = dlc; ld_data = data; ld_tag = tag;
      cyc(1);
      ld_valid = 0;
   endtask

   task automatic load_tag(input logic [7:0] tag);
      load(1'b1, {21'h0, tag}, 4'd8, {8{tag}}, tag);
   endtask

   task automatic pulse_ok();
      eng_ok = 1; cyc(1); eng_ok = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1;
      cyc(1);
      chk("R6 reset req", eng_req, 0);
      chk("R1 reset count", q_count, 0);
      chk("R11 reset flag", bus_err, 0);
      chk("R7 reset pend", single_pend, 0);

      // R3 R4 R5 formatting vectors, continuous enable
      en_pin = 1;
      for (int i = 0; i < 5; i++) begin
         load(VEC[i].ide, VEC[i].id, VEC[i].dlc, VEC[i].data, VEC[i].tag);
         cyc(1);
         chk("R6 req", eng_req, 1);
         chk("R3 id", eng_id, VEC[i].eid);
         chk("R4 dlc", eng_dlc, VEC[i].edlc);
         chk("R4 data", eng_data, VEC[i].edata);
         chk("R5 tag", eng_tag, VEC[i].tag);
         pulse_ok();
      end
      en_pin = 0;
      cyc(1);

      // R1 fill past depth, then drain in order (R6)
      for (int i = 0; i < 9; i++) load_tag(8'(i));
      chk("R1 count", q_count, 8);
      chk("R1 full", q_full, 1);
      chk("R8 idle when disabled", eng_req, 0);
      en_pin = 1;
      cyc(1);
      for (int i = 0; i < 8; i++) begin
         chk("R6 order", eng_tag, 8'(i));
         pulse_ok();
         cyc(1);
      end
      chk("R1 ninth dropped req", eng_req, 0);
      chk("R1 ninth dropped count", q_count, 0);
      en_pin = 0;

      // R2 clear with simultaneous load
      load_tag(8'h30); load_tag(8'h31); load_tag(8'h32);
      chk("R2 before", q_count, 3);
      q_clear = 1; ld_valid = 1; ld_tag = 8'h77;
      cyc(1);
      q_clear = 0; ld_valid = 0;
      chk("R2 cleared", q_count, 0);

      // R7 single message
      load_tag(8'h40); load_tag(8'h41);
      single_req = 1; cyc(1); single_req = 0;
      chk("R7 pend set", single_pend, 1);
      cyc(1);
      chk("R7 sent", eng_tag, 8'h40);
      chk("R7 req", eng_req, 1);
      chk("R7 pend self-clear", single_pend, 0);
      pulse_ok();
      cyc(3);
      chk("R7 only one req", eng_req, 0);
      chk("R7 only one count", q_count, 1);

      // R8 pause mid transmission
      load_tag(8'h42);
      en_bit = 1; cyc(1);
      chk("R8 start", eng_tag, 8'h41);
      en_bit = 0; cyc(3);
      chk("R8 finishes req", eng_req, 1);
      chk("R8 finishes tag", eng_tag, 8'h41);
      pulse_ok(); cyc(2);
      chk("R8 no next", eng_req, 0);
      chk("R8 remains", q_count, 1);

      // R9 retry, R11 error flag
      en_pin = 1; cyc(1);
      chk("R9 held", eng_tag, 8'h42);
      eng_lost = 1; cyc(1); eng_lost = 0;
      chk("R9 lost retry req", eng_req, 1);
      chk("R9 lost retry tag", eng_tag, 8'h42);
      eng_err = 1; cyc(1); eng_err = 0;
      chk("R9 err retry req", eng_req, 1);
      chk("R11 flag set", bus_err, 1);
      chk("R11 irq masked", irq, 0);
      cyc(2);
      chk("R11 sticky", bus_err, 1);
      err_ie = 1; #1;
      chk("R11 irq", irq, 1);
      err_clr = 1; cyc(1); err_clr = 0;
      chk("R11 cleared", bus_err, 0);
      chk("R11 irq cleared", irq, 0);
      pulse_ok(); cyc(1);

      // R10 one-shot drops
      oneshot = 1;
      load_tag(8'h50); load_tag(8'h51);
      chk("R10 first", eng_tag, 8'h50);
      eng_lost = 1; cyc(1); eng_lost = 0;
      chk("R10 lost dropped", eng_req, 0);
      cyc(1);
      chk("R10 next loaded", eng_tag, 8'h51);
      eng_err = 1; cyc(1); eng_err = 0;
      chk("R10 err dropped", eng_req, 0);
      chk("R11 err in oneshot", bus_err, 1);
      cyc(2);
      chk("R10 queue empty", eng_req, 0);
      oneshot = 0;

      // R12 abort
      load_tag(8'h60); load_tag(8'h61);
      chk("R12 held", eng_tag, 8'h60);
      abort_cmd = 1; cyc(1); abort_cmd = 0;
      chk("R12 aborted", eng_req, 0);
      chk("R12 queue kept", q_count, 1);
      cyc(1);
      chk("R12 next", eng_tag, 8'h61);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule